// File: doc/BRIEF.md
# Barrel Operand Shifter with Carry

This block prepares the second operand of an integer datapath before it reaches the adder or logic unit. A 32-bit operand is moved left or right, arithmetically shifted, rotated, or rotated by one place through the carry flag. The block returns the moved value and a shifter carry that the flag logic may use.

The distance comes from one of two places. A 5-bit field from the instruction word can supply it. The low byte of a general register can supply it instead. A select input picks the source. In immediate mode a field of zero has a special meaning for each kind of shift. In register mode the whole byte is used, so distances of 32 or more are defined. The result and the carry are registered once. They appear one clock after the inputs are presented.

Top module: `shf_operand_shifter`

## Requirements
- R1: The kind code 0 selects a left logical shift. An immediate distance n from 1 to 31 fills the low n bits with zeros and returns operand bit 32-n as carry. An immediate field of 0 passes the operand through unchanged and returns the incoming carry.
- R2: The kind code 1 selects a right logical shift with zero fill. An immediate distance n from 1 to 31 returns operand bit n-1 as carry. An immediate field of 0 means a distance of 32: the result is zero and the carry is operand bit 31.
- R3: The kind code 2 selects an arithmetic right shift. Every vacated bit takes the old bit 31. An immediate field of 0 means 32: every result bit and the carry equal the old bit 31.
- R4: The kind code 3 with an immediate field from 1 to 31 rotates right. Bits leaving bit 0 re-enter at bit 31. The carry is the new bit 31.
- R5: The kind code 3 with an immediate field of 0 moves bits [31:1] down one place and puts the incoming carry into bit 31. The carry out is the old bit 0.
- R6: When the register select is 1, the distance is bits [7:0] of the register amount input, and the immediate field has no effect.
- R7: A register distance of 0 passes the operand through unchanged for every kind and returns the incoming carry.
- R8: For logical shifts, a register distance of 32 gives a zero result. The carry is operand bit 0 for a left shift and operand bit 31 for a right shift. A distance above 32 gives a zero result and a zero carry.
- R9: For an arithmetic right shift, a register distance of 32 or more fills every result bit and the carry with the old bit 31.
- R10: For a rotate, a nonzero register distance acts as its value modulo 32. A nonzero multiple of 32 leaves the operand unchanged and returns operand bit 31 as carry.
- R11: The outputs update one clock after the inputs. A synchronous active-high reset clears the result and the carry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | 32 | Operand to transform |
| kind_i | input | 2 | Shift kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate |
| use_reg_i | input | 1 | 1 takes the distance from reg_amt_i, 0 from imm_amt_i |
| imm_amt_i | input | 5 | Immediate distance field |
| reg_amt_i | input | 8 | Register distance (low byte of a register) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Transformed operand, registered |
| carry_o | output | 1 | Shifter carry out, registered |

## Verification
Directed vectors cover each immediate field of zero and each register distance that sits on a boundary: 0, 1, 31, 32, 33, 64 and 255. They tell the zero encodings of the four kinds apart, and they tell a distance of exactly 32 apart from one beyond it. Operands with bit 31 set and with bit 31 clear show sign fill apart from zero fill. Operands with different end bits show which bit is returned as carry. Random vectors from a fixed seed cover the rest of the kind, source and distance space. Every vector is checked against a reference that moves the operand one bit per step.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IMM_W  = $clog2(DATA_W);
    localparam int unsigned RAMT_W = 8;
    localparam int unsigned CNT_W  = $clog2(DATA_W) + 1;

    // Shift kind as encoded by the instruction field
    typedef enum logic [1:0] {
        K_LSL = 2'd0,
        K_LSR = 2'd1,
        K_ASR = 2'd2,
        K_ROR = 2'd3
    } shf_kind_e;

    // Resolved operation after distance decoding
    typedef enum logic [2:0] {
        M_PASS,
        M_LSL,
        M_LSR,
        M_ASR,
        M_ROR,
        M_RRX
    } shf_mode_e;

    typedef struct packed {
        shf_mode_e          mode;
        logic [CNT_W-1:0]   cnt;   // 0..DATA_W+1, DATA_W+1 means "beyond width"
    } shf_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } shf_res_t;

    function automatic logic is_logical(shf_kind_e k);
        return (k == K_LSL) || (k == K_LSR);
    endfunction

endpackage

// File: rtl/shf_amt_dec.sv
module shf_amt_dec
    import shf_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned IW  = IMM_W,
    parameter int unsigned RW  = RAMT_W,
    parameter int unsigned CW  = CNT_W
) (
    input  shf_kind_e       kind,
    input  logic            use_reg,
    input  logic [IW-1:0]   imm_amt,
    input  logic [RW-1:0]   reg_amt,
    output shf_cmd_t        cmd
);

    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] OVER = CW'(DW + 1);

    logic [IW-1:0] rot_low;
    assign rot_low = reg_amt[IW-1:0];

    always_comb begin
        cmd.mode = M_PASS;
        cmd.cnt  = '0;
        if (!use_reg) begin
            if (imm_amt == '0) begin
                unique case (kind)
                    K_LSL: cmd.mode = M_PASS;
                    K_LSR: begin cmd.mode = M_LSR; cmd.cnt = FULL; end
                    K_ASR: begin cmd.mode = M_ASR; cmd.cnt = FULL; end
                    K_ROR: begin cmd.mode = M_RRX; cmd.cnt = CW'(1); end
                    default: cmd.mode = M_PASS;
                endcase
            end else begin
                cmd.cnt = CW'(imm_amt);
                unique case (kind)
                    K_LSL:   cmd.mode = M_LSL;
                    K_LSR:   cmd.mode = M_LSR;
                    K_ASR:   cmd.mode = M_ASR;
                    default: cmd.mode = M_ROR;
                endcase
            end
        end else if (reg_amt != '0) begin
            unique case (kind)
                K_LSL, K_LSR: begin
                    cmd.mode = (kind == K_LSL) ? M_LSL : M_LSR;
                    cmd.cnt  = (32'(reg_amt) > DW) ? OVER : CW'(reg_amt);
                end
                K_ASR: begin
                    cmd.mode = M_ASR;
                    cmd.cnt  = (32'(reg_amt) >= DW) ? FULL : CW'(reg_amt);
                end
                default: begin
                    cmd.mode = M_ROR;
                    cmd.cnt  = (rot_low == '0) ? FULL : CW'(rot_low);
                end
            endcase
        end
    end

endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CW = CNT_W
) (
    input  shf_cmd_t        cmd,
    input  logic [DW-1:0]   opnd,
    input  logic            carry_in,
    output shf_res_t        res
);

    logic [DW:0]          left_w;
    logic [DW:0]          right_w;
    logic signed [DW:0]   arith_w;
    logic [DW-1:0]        rot_w;
    logic [CW-1:0]        back_cnt;

    always_comb begin
        back_cnt = CW'(DW) - cmd.cnt;
        left_w   = {1'b0, opnd} << cmd.cnt;
        right_w  = {opnd, 1'b0} >> cmd.cnt;
        arith_w  = $signed({opnd, 1'b0}) >>> cmd.cnt;
        rot_w    = (opnd >> cmd.cnt) | (opnd << back_cnt);
    end

    always_comb begin
        unique case (cmd.mode)
            M_LSL:   begin res.value = left_w[DW-1:0];  res.carry = left_w[DW];  end
            M_LSR:   begin res.value = right_w[DW:1];   res.carry = right_w[0];  end
            M_ASR:   begin res.value = arith_w[DW:1];   res.carry = arith_w[0];  end
            M_ROR:   begin res.value = rot_w;           res.carry = rot_w[DW-1]; end
            M_RRX:   begin res.value = {carry_in, opnd[DW-1:1]}; res.carry = opnd[0]; end
            default: begin res.value = opnd;            res.carry = carry_in;    end
        endcase
    end

endmodule

// File: rtl/shf_operand_shifter.sv
module shf_operand_shifter
    import shf_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned IW = IMM_W,
    parameter int unsigned RW = RAMT_W,
    parameter int unsigned CW = CNT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   opnd_i,
    input  logic [1:0]      kind_i,
    input  logic            use_reg_i,
    input  logic [IW-1:0]   imm_amt_i,
    input  logic [RW-1:0]   reg_amt_i,
    input  logic            carry_i,
    output logic [DW-1:0]   result_o,
    output logic            carry_o
);

    shf_kind_e kind;
    shf_cmd_t  cmd;
    shf_res_t  nxt;

    assign kind = shf_kind_e'(kind_i);

    shf_amt_dec #(.DW(DW), .IW(IW), .RW(RW), .CW(CW)) u_dec (
        .kind    (kind),
        .use_reg (use_reg_i),
        .imm_amt (imm_amt_i),
        .reg_amt (reg_amt_i),
        .cmd     (cmd)
    );

    shf_core #(.DW(DW), .CW(CW)) u_core (
        .cmd      (cmd),
        .opnd     (opnd_i),
        .carry_in (carry_i),
        .res      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else begin
            result_o <= nxt.value;
            carry_o  <= nxt.carry;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result_o == '0) && !carry_o); // R11

    AST_RRX_INSERT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind_i) == 2'd3 && !$past(use_reg_i) && $past(imm_amt_i) == '0)
        |-> (result_o == {$past(carry_i), $past(opnd_i[DW-1:1])}) && (carry_o == $past(opnd_i[0]))); // R5

    AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(use_reg_i) && $past(reg_amt_i) == '0)
        |-> (result_o == $past(opnd_i)) && (carry_o == $past(carry_i))); // R7

    AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(use_reg_i) && $past(kind_i[1]) == 1'b0 && 32'($past(reg_amt_i)) > DW)
        |-> (result_o == '0) && !carry_o); // R8

    AST_ASR_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(use_reg_i) && $past(kind_i) == 2'd2 && 32'($past(reg_amt_i)) >= DW)
        |-> (result_o == {DW{$past(opnd_i[DW-1])}}) && (carry_o == $past(opnd_i[DW-1]))); // R9

    AST_IMM_LSL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(use_reg_i) && $past(kind_i) == 2'd0 && $past(imm_amt_i) == '0)
        |-> (result_o == $past(opnd_i)) && (carry_o == $past(carry_i))); // R1

endmodule

// File: tb/shf_operand_shifter_tb.sv
module shf_operand_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opnd;
    logic [1:0]  kind;
    logic        use_reg;
    logic [4:0]  imm_amt;
    logic [7:0]  reg_amt;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shf_operand_shifter dut_i (
        .clk(clk), .rst(rst), .opnd_i(opnd), .kind_i(kind), .use_reg_i(use_reg),
        .imm_amt_i(imm_amt), .reg_amt_i(reg_amt), .carry_i(cin),
        .result_o(result), .carry_o(cout)
    );

    // Reference: step the operand one bit at a time
    function automatic logic [32:0] ref_model(logic [31:0] v, logic [1:0] k, logic ur,
                                              logic [4:0] im, logic [7:0] ra, logic c);
        int   n;
        logic [31:0] w = v;
        logic co = c;
        if (ur) n = ra;
        else if (im != 0) n = im;
        else if (k == 2'd0) n = 0;
        else if (k == 2'd3) return {v[0], c, v[31:1]};
        else n = 32;
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin co = w[31]; w = {w[30:0], 1'b0}; end
                2'd1: begin co = w[0];  w = {1'b0, w[31:1]}; end
                2'd2: begin co = w[0];  w = {w[31], w[31:1]}; end
                default: begin co = w[0]; w = {w[0], w[31:1]}; end
            endcase
        end
        return {co, w};
    endfunction

    task automatic run(logic [31:0] v, logic [1:0] k, logic ur, logic [4:0] im,
                       logic [7:0] ra, logic c, string req);
        logic [32:0] exp;
        @(negedge clk);
        opnd = v; kind = k; use_reg = ur; imm_amt = im; reg_amt = ra; cin = c;
        exp = ref_model(v, k, ur, im, ra, c);
        @(posedge clk);
        #1;
        checks++;
        if ({cout, result} !== exp) begin
            errors++;
            $display("FAIL %s: got res=%h c=%b expected res=%h c=%b (op=%h k=%0d reg=%0b imm=%0d ramt=%0d cin=%b)",
                     req, result, cout, exp[31:0], exp[32], v, k, ur, im, ra, c);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; opnd = 32'hFFFF_FFFF; kind = 2'd3; use_reg = 1'b0;
        imm_amt = 5'd0; reg_amt = 8'd0; cin = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result !== 32'h0 || cout !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got res=%h c=%b expected res=0 c=0", result, cout);
        end
        @(negedge clk); rst = 1'b0;

        // R1 left logical immediate
        run(32'h8000_0001, 2'd0, 1'b0, 5'd1,  8'd0, 1'b0, "R1 lsl #1");
        run(32'h4000_000F, 2'd0, 1'b0, 5'd31, 8'd0, 1'b0, "R1 lsl #31");
        run(32'h1234_5678, 2'd0, 1'b0, 5'd0,  8'd0, 1'b1, "R1 lsl #0 pass");
        // R2 right logical immediate
        run(32'h8000_0003, 2'd1, 1'b0, 5'd2,  8'd0, 1'b0, "R2 lsr #2");
        run(32'h8000_0000, 2'd1, 1'b0, 5'd0,  8'd0, 1'b0, "R2 lsr #32");
        // R3 arithmetic
        run(32'h8000_0010, 2'd2, 1'b0, 5'd4,  8'd0, 1'b0, "R3 asr #4 neg");
        run(32'h7000_0010, 2'd2, 1'b0, 5'd5,  8'd0, 1'b1, "R3 asr #5 pos");
        run(32'h8765_4321, 2'd2, 1'b0, 5'd0,  8'd0, 1'b0, "R3 asr #32 neg");
        run(32'h0765_4321, 2'd2, 1'b0, 5'd0,  8'd0, 1'b1, "R3 asr #32 pos");
        // R4 rotate
        run(32'h0000_0001, 2'd3, 1'b0, 5'd1,  8'd0, 1'b0, "R4 ror #1");
        run(32'hABCD_EF01, 2'd3, 1'b0, 5'd31, 8'd0, 1'b0, "R4 ror #31");
        // R5 rotate through carry
        run(32'h0000_0003, 2'd3, 1'b0, 5'd0,  8'd0, 1'b1, "R5 rrx c=1");
        run(32'hFFFF_FFFE, 2'd3, 1'b0, 5'd0,  8'd0, 1'b0, "R5 rrx c=0");
        // R6 register source ignores immediate
        run(32'h0000_00F0, 2'd1, 1'b1, 5'd9,  8'd4, 1'b0, "R6 reg lsr 4");
        run(32'h0000_00F0, 2'd0, 1'b1, 5'd0,  8'd3, 1'b1, "R6 reg lsl 3");
        // R7 register zero
        for (int k = 0; k < 4; k++)
            run(32'hC0DE_0001, 2'(k), 1'b1, 5'd7, 8'd0, 1'b1, "R7 reg 0 pass");
        // R8 logical at/over 32
        run(32'h8000_0001, 2'd0, 1'b1, 5'd0, 8'd32,  1'b0, "R8 lsl 32");
        run(32'h8000_0001, 2'd1, 1'b1, 5'd0, 8'd32,  1'b0, "R8 lsr 32");
        run(32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 8'd33,  1'b1, "R8 lsl 33");
        run(32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd255, 1'b1, "R8 lsr 255");
        // R9 arithmetic beyond
        run(32'h8000_0000, 2'd2, 1'b1, 5'd0, 8'd32,  1'b0, "R9 asr 32");
        run(32'h9000_0000, 2'd2, 1'b1, 5'd0, 8'd200, 1'b0, "R9 asr 200");
        run(32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 8'd40,  1'b1, "R9 asr 40 pos");
        // R10 rotate modulo
        run(32'h8000_1234, 2'd3, 1'b1, 5'd0, 8'd32,  1'b0, "R10 ror 32");
        run(32'h0000_1234, 2'd3, 1'b1, 5'd0, 8'd64,  1'b1, "R10 ror 64");
        run(32'h0000_1234, 2'd3, 1'b1, 5'd0, 8'd36,  1'b0, "R10 ror 36");
        run(32'h8000_0001, 2'd3, 1'b1, 5'd0, 8'd255, 1'b0, "R10 ror 255");

        // Random mix (R6 and all kinds)
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ra;
            ra = (i % 3 == 0) ? 8'($urandom_range(0, 40)) : 8'($urandom);
            run($urandom, 2'($urandom), 1'($urandom), 5'($urandom), ra, 1'($urandom),
                "R6 random");
        end

        // R11 mid-run reset clears outputs
        @(negedge clk);
        rst = 1'b1; opnd = 32'hFFFF_FFFF; kind = 2'd0; use_reg = 1'b0; imm_amt = 5'd0; cin = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (result !== 32'h0 || cout !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset mid-run: got res=%h c=%b expected res=0 c=0", result, cout);
        end
        @(negedge clk); rst = 1'b0;
        run(32'h0000_0100, 2'd1, 1'b0, 5'd8, 8'd0, 1'b0, "R11 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule